// File: doc/BRIEF.md
# Fully Associative TLB with ASID-Selective Invalidation

This block is a small, fully associative translation buffer with a parameterised number of entries. Each entry holds a double-page tag, an 8-bit address-space identifier, a global bit and two page mappings, one for the even page and one for the odd page. Each mapping carries a frame number, a cache attribute, a dirty bit and a valid bit. A separate per-entry hide flag keeps an entry out of every match. The hide flag can be set in three ways: a bulk command that hides every non-global entry owned by one address space, a bulk command that hides every entry, or an indexed write whose tag image has the hide bit raised.

Software works on the block through a tag-image register, here called the high image. Indexed writes take their tag and address-space fields from this image, and the probe and the address-space invalidate take their selection fields from it. The page fields of an indexed write come from two low-word images supplied with the write strobe. An indexed read returns the stored entry as the same three register images.

Translation is a combinational lookup. It uses the address-space identifier held in the high image. A two-bit capability input switches the invalidate features on or off. The page size is fixed at 4 KiB.

Top module: `tlb_asid_inv`

## Requirements
- R1: While reset is active, every entry is hidden and the high image is cleared. Until an entry has been written, no lookup hits and every probe misses.
- R2: A lookup hits an entry only when all of these hold: the entry is not hidden, its tag equals virtual address bits 31:13, and either its global bit is 1 or its address-space field equals high-image bits 7:0. When several entries match, the lowest-numbered one is used.
- R3: On a hit, virtual address bit 12 selects the odd mapping (1) or the even mapping (0). The physical address is the selected frame number concatenated with virtual address bits 11:0. The selected attribute, dirty bit and valid bit are presented on their outputs.
- R4: An indexed write with high-image bit 10 clear clears the entry's hide flag. It loads the tag from high-image bits 31:13 and the address-space field from bits 7:0. It loads the global bit as the AND of bit 0 of both low words. Each mapping is loaded from its low word: valid in bit 1, dirty in bit 2, attribute in bits 5:3, frame number in bits 25:6.
- R5: An indexed write with high-image bit 10 set only hides the addressed entry. After such a write, that entry no longer takes part in any match.
- R6: An indexed read of a hidden entry returns a high word with only bit 10 set and two low words of zero.
- R7: An indexed read of a visible entry returns the tag in bits 31:13 and the address-space field in bits 7:0 of the high word. Each low word uses the R4 layout, with the global bit in bit 0 of both. Read results appear with a one-cycle valid pulse on the edge after the read strobe.
- R8: The address-space invalidate hides every entry whose global bit is 0 and whose address-space field equals high-image bits 7:0. The tag bits of the high image play no part in the selection. Global entries and entries of other address spaces stay visible.
- R9: The invalidate-all command hides every entry, global or not, in one cycle.
- R10: When the capability input is below 2, both invalidate commands do nothing, and bit 10 of a high-image write is stored as 0.
- R11: A high-image write keeps only bits 31:13 and bits 7:0, plus bit 10 when the capability input is 2 or more. Every other bit is stored as 0.
- R12: A probe compares the high-image tag and address-space field against the entries, using the R2 rules. One cycle after the strobe it raises a valid pulse with the lowest matching index in the low bits. On a miss, the index word has bit 31 set and all other bits 0.
- R13: One command runs per cycle, with this priority: write, invalidate-all, invalidate-by-space, read, probe. The lower-priority commands raised in the same cycle have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ie_cap | input | 2 | Invalidate capability level; features on at 2 or more |
| hi_wr | input | 1 | Load the high image from hi_wdata |
| hi_wdata | input | 32 | New high-image value before masking |
| hi_img | output | 32 | Current high image |
| ent_idx | input | IDX_W | Entry index for write and read |
| lo0_in | input | 26 | Even-page low word for a write |
| lo1_in | input | 26 | Odd-page low word for a write |
| wr_en | input | 1 | Indexed write strobe |
| rd_en | input | 1 | Indexed read strobe |
| probe_en | input | 1 | Probe strobe |
| inv_asid_en | input | 1 | Invalidate-by-address-space strobe |
| inv_all_en | input | 1 | Invalidate-all strobe |
| lk_va | input | 32 | Virtual address for lookup |
| lk_hit | output | 1 | Lookup hit |
| lk_pa | output | 32 | Translated physical address (0 on miss) |
| lk_valid | output | 1 | Valid bit of selected page |
| lk_dirty | output | 1 | Dirty bit of selected page |
| lk_attr | output | 3 | Cache attribute of selected page |
| prb_valid | output | 1 | Probe result pulse |
| prb_index | output | 32 | Probe result index, bit 31 flags a miss |
| rd_valid | output | 1 | Read result pulse |
| rd_hi | output | 32 | Read-back high word |
| rd_lo0 | output | 32 | Read-back even low word |
| rd_lo1 | output | 32 | Read-back odd low word |

## Verification
The hardest state to reach from the ports is a table where duplicate tags, global entries and several address spaces live side by side at the moment an address-space invalidate or a probe runs. Only that mix shows the lowest-index rule and the sparing of global entries at work. The directed phase writes two entries with the same tag on purpose and marks some entries global. The random phase then draws tags and address spaces from a pool of three or four values, so collisions are frequent. It also raises strobes together so that priority is exercised, and it changes the capability level from time to time. A behavioural table model is compared against every output on every cycle.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    parameter int VA_W        = 32;
    parameter int REG_W       = 32;
    parameter int PAGE_SHIFT  = 12;
    parameter int ASID_W      = 8;
    parameter int PFN_W       = 20;
    parameter int ATTR_W      = 3;
    parameter int HI_HIDE_BIT = 10;
    parameter int IE_MIN      = 2;

    localparam int VPN2_LSB   = PAGE_SHIFT + 1;
    localparam int VPN2_W     = VA_W - VPN2_LSB;
    localparam int LO_ATTR_LSB = 3;
    localparam int LO_PFN_LSB = LO_ATTR_LSB + ATTR_W;
    localparam int LO_W       = LO_PFN_LSB + PFN_W;
    localparam int PA_W       = PFN_W + PAGE_SHIFT;

    typedef struct packed {
        logic [PFN_W-1:0]  pfn;
        logic [ATTR_W-1:0] attr;
        logic              dirty;
        logic              valid;
    } page_t;

    typedef struct packed {
        logic [VPN2_W-1:0] vpn2;
        logic [ASID_W-1:0] asid;
        logic              glob;
        logic              hidden;
        page_t             even;
        page_t             odd;
    } tlb_ent_t;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_WRITE,
        CMD_INV_ALL,
        CMD_INV_ASID,
        CMD_READ,
        CMD_PROBE
    } tlb_cmd_e;

    function automatic page_t lo_unpack(input logic [LO_W-1:0] lo);
        page_t p;
        p.valid = lo[1];
        p.dirty = lo[2];
        p.attr  = lo[LO_ATTR_LSB +: ATTR_W];
        p.pfn   = lo[LO_PFN_LSB +: PFN_W];
        return p;
    endfunction

    function automatic logic [REG_W-1:0] lo_pack(input page_t p, input logic g);
        logic [REG_W-1:0] w;
        w = '0;
        w[0] = g;
        w[1] = p.valid;
        w[2] = p.dirty;
        w[LO_ATTR_LSB +: ATTR_W] = p.attr;
        w[LO_PFN_LSB +: PFN_W]   = p.pfn;
        return w;
    endfunction

    function automatic logic [REG_W-1:0] hi_keep_mask(input logic hide_ok);
        logic [REG_W-1:0] m;
        m = '0;
        m[REG_W-1:VPN2_LSB] = '1;
        m[ASID_W-1:0]       = '1;
        m[HI_HIDE_BIT]      = hide_ok;
        return m;
    endfunction

    function automatic logic [REG_W-1:0] hi_pack(input tlb_ent_t e);
        logic [REG_W-1:0] w;
        w = '0;
        w[VPN2_LSB +: VPN2_W] = e.vpn2;
        w[ASID_W-1:0]         = e.asid;
        return w;
    endfunction

endpackage

// File: rtl/tlb_cmd_arb.sv
module tlb_cmd_arb
    import tlb_pkg::*;
(
    input  logic     wr_req,
    input  logic     rd_req,
    input  logic     probe_req,
    input  logic     inv_asid_req,
    input  logic     inv_all_req,
    input  logic     inv_ok,
    output tlb_cmd_e cmd
);

    always_comb begin
        if (wr_req)                        cmd = CMD_WRITE;
        else if (inv_all_req && inv_ok)    cmd = CMD_INV_ALL;
        else if (inv_asid_req && inv_ok)   cmd = CMD_INV_ASID;
        else if (rd_req)                   cmd = CMD_READ;
        else if (probe_req)                cmd = CMD_PROBE;
        else                               cmd = CMD_NONE;
    end

endmodule

// File: rtl/tlb_hi_reg.sv
module tlb_hi_reg
    import tlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             hide_ok,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] img
);

    always_ff @(posedge clk) begin
        if (rst) begin
            img <= '0;
        end else if (wr) begin
            img <= wdata & hi_keep_mask(hide_ok);
        end
    end

endmodule

// File: rtl/tlb_first_hit.sv
module tlb_first_hit #(
    parameter int N_ENTRIES = 8,
    localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic [N_ENTRIES-1:0] match,
    output logic                 any,
    output logic [IDX_W-1:0]     idx
);

    always_comb begin
        any = |match;
        idx = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
    import tlb_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  tlb_cmd_e                    cmd,
    input  logic [IDX_W-1:0]            idx,
    input  logic [VPN2_W-1:0]           hi_vpn2,
    input  logic [ASID_W-1:0]           hi_asid,
    input  logic                        hi_hide,
    input  logic [LO_W-1:0]             lo0,
    input  logic [LO_W-1:0]             lo1,
    input  logic [VPN2_W-1:0]           lk_vpn2,
    output tlb_ent_t [N_ENTRIES-1:0]    ents,
    output logic [N_ENTRIES-1:0]        lk_match,
    output logic [N_ENTRIES-1:0]        prb_match
);

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
        tlb_ent_t ent_q;
        logic     own_space;

        assign own_space = ent_q.glob || (ent_q.asid == hi_asid);

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q        <= '0;
                ent_q.hidden <= 1'b1;
            end else if (cmd == CMD_WRITE && idx == IDX_W'(g)) begin
                if (hi_hide) begin
                    ent_q.hidden <= 1'b1;
                end else begin
                    ent_q.hidden <= 1'b0;
                    ent_q.vpn2   <= hi_vpn2;
                    ent_q.asid   <= hi_asid;
                    ent_q.glob   <= lo0[0] & lo1[0];
                    ent_q.even   <= lo_unpack(lo0);
                    ent_q.odd    <= lo_unpack(lo1);
                end
            end else if (cmd == CMD_INV_ALL) begin
                ent_q.hidden <= 1'b1;
            end else if (cmd == CMD_INV_ASID && !ent_q.glob && ent_q.asid == hi_asid) begin
                ent_q.hidden <= 1'b1;
            end
        end

        assign ents[g]      = ent_q;
        assign lk_match[g]  = !ent_q.hidden && own_space && (ent_q.vpn2 == lk_vpn2);
        assign prb_match[g] = !ent_q.hidden && own_space && (ent_q.vpn2 == hi_vpn2);
    end

endmodule

// File: rtl/tlb_asid_inv.sv
module tlb_asid_inv
    import tlb_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        ie_cap,
    input  logic              hi_wr,
    input  logic [REG_W-1:0]  hi_wdata,
    output logic [REG_W-1:0]  hi_img,
    input  logic [IDX_W-1:0]  ent_idx,
    input  logic [LO_W-1:0]   lo0_in,
    input  logic [LO_W-1:0]   lo1_in,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              probe_en,
    input  logic              inv_asid_en,
    input  logic              inv_all_en,
    input  logic [VA_W-1:0]   lk_va,
    output logic              lk_hit,
    output logic [PA_W-1:0]   lk_pa,
    output logic              lk_valid,
    output logic              lk_dirty,
    output logic [ATTR_W-1:0] lk_attr,
    output logic              prb_valid,
    output logic [REG_W-1:0]  prb_index,
    output logic              rd_valid,
    output logic [REG_W-1:0]  rd_hi,
    output logic [REG_W-1:0]  rd_lo0,
    output logic [REG_W-1:0]  rd_lo1
);

    logic                     inv_ok;
    tlb_cmd_e                 cmd;
    tlb_ent_t [N_ENTRIES-1:0] ents;
    logic [N_ENTRIES-1:0]     lk_match;
    logic [N_ENTRIES-1:0]     prb_match;
    logic                     lk_any;
    logic [IDX_W-1:0]         lk_idx;
    logic                     prb_any;
    logic [IDX_W-1:0]         prb_idx;
    tlb_ent_t                 lk_ent;
    page_t                    lk_page;
    tlb_ent_t                 rd_ent;

    assign inv_ok = (ie_cap >= 2'(IE_MIN));

    tlb_cmd_arb arb_i (
        .wr_req      (wr_en),
        .rd_req      (rd_en),
        .probe_req   (probe_en),
        .inv_asid_req(inv_asid_en),
        .inv_all_req (inv_all_en),
        .inv_ok      (inv_ok),
        .cmd         (cmd)
    );

    tlb_hi_reg hi_i (
        .clk    (clk),
        .rst    (rst),
        .hide_ok(inv_ok),
        .wr     (hi_wr),
        .wdata  (hi_wdata),
        .img    (hi_img)
    );

    tlb_entry_array #(.N_ENTRIES(N_ENTRIES)) arr_i (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .idx      (ent_idx),
        .hi_vpn2  (hi_img[VPN2_LSB +: VPN2_W]),
        .hi_asid  (hi_img[ASID_W-1:0]),
        .hi_hide  (hi_img[HI_HIDE_BIT]),
        .lo0      (lo0_in),
        .lo1      (lo1_in),
        .lk_vpn2  (lk_va[VA_W-1:VPN2_LSB]),
        .ents     (ents),
        .lk_match (lk_match),
        .prb_match(prb_match)
    );

    tlb_first_hit #(.N_ENTRIES(N_ENTRIES)) lk_sel_i (
        .match(lk_match),
        .any  (lk_any),
        .idx  (lk_idx)
    );

    tlb_first_hit #(.N_ENTRIES(N_ENTRIES)) prb_sel_i (
        .match(prb_match),
        .any  (prb_any),
        .idx  (prb_idx)
    );

    // Combinational translation: pick the half by the bit above the page offset
    assign lk_ent   = ents[lk_idx];
    assign lk_page  = lk_va[PAGE_SHIFT] ? lk_ent.odd : lk_ent.even;
    assign lk_hit   = lk_any;
    assign lk_pa    = lk_any ? {lk_page.pfn, lk_va[PAGE_SHIFT-1:0]} : '0;
    assign lk_valid = lk_any & lk_page.valid;
    assign lk_dirty = lk_any & lk_page.dirty;
    assign lk_attr  = lk_any ? lk_page.attr : '0;

    assign rd_ent = ents[ent_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            prb_valid <= 1'b0;
            prb_index <= '0;
            rd_valid  <= 1'b0;
            rd_hi     <= '0;
            rd_lo0    <= '0;
            rd_lo1    <= '0;
        end else begin
            prb_valid <= (cmd == CMD_PROBE);
            rd_valid  <= (cmd == CMD_READ);
            if (cmd == CMD_PROBE) begin
                prb_index <= {~prb_any, {(REG_W-1-IDX_W){1'b0}}, prb_idx};
            end
            if (cmd == CMD_READ) begin
                if (rd_ent.hidden) begin
                    rd_hi  <= REG_W'(1) << HI_HIDE_BIT;
                    rd_lo0 <= '0;
                    rd_lo1 <= '0;
                end else begin
                    rd_hi  <= hi_pack(rd_ent);
                    rd_lo0 <= lo_pack(rd_ent.even, rd_ent.glob);
                    rd_lo1 <= lo_pack(rd_ent.odd, rd_ent.glob);
                end
            end
        end
    end

endmodule

// File: rtl/tlb_asid_inv_chk.sv
module tlb_asid_inv_chk
    import tlb_pkg::*;
#(
    parameter int N_ENTRIES = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       ie_cap,
    input logic             hi_wr,
    input logic [REG_W-1:0] hi_img,
    input logic             wr_en,
    input logic             probe_en,
    input tlb_cmd_e         cmd,
    input logic             lk_hit,
    input logic             prb_valid,
    input logic [REG_W-1:0] prb_index,
    input logic             rd_valid,
    input logic [REG_W-1:0] rd_hi,
    input logic [REG_W-1:0] rd_lo0,
    input logic [REG_W-1:0] rd_lo1
);

    // R1
    reset_hides_all_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !lk_hit);

    // R6
    rd_hidden_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_hi[HI_HIDE_BIT]) |-> (rd_lo0 == '0 && rd_lo1 == '0));

    // R9
    inv_all_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_INV_ALL) |=> !lk_hit);

    // R10
    hide_bit_gated_chk: assert property (@(posedge clk) disable iff (rst)
        (hi_wr && ie_cap < 2'(IE_MIN)) |=> !hi_img[HI_HIDE_BIT]);

    // R12
    probe_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_PROBE) |=> prb_valid);

    // R12
    probe_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !probe_en |=> !prb_valid);

    // R12
    probe_range_chk: assert property (@(posedge clk) disable iff (rst)
        (prb_valid && !prb_index[REG_W-1]) |-> (prb_index < REG_W'(N_ENTRIES)));

    // R13
    write_wins_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (!prb_valid && !rd_valid));

endmodule

bind tlb_asid_inv tlb_asid_inv_chk #(.N_ENTRIES(N_ENTRIES)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .ie_cap   (ie_cap),
    .hi_wr    (hi_wr),
    .hi_img   (hi_img),
    .wr_en    (wr_en),
    .probe_en (probe_en),
    .cmd      (cmd),
    .lk_hit   (lk_hit),
    .prb_valid(prb_valid),
    .prb_index(prb_index),
    .rd_valid (rd_valid),
    .rd_hi    (rd_hi),
    .rd_lo0   (rd_lo0),
    .rd_lo1   (rd_lo1)
);

// File: tb/tlb_asid_inv_tb_top.sv
module tlb_asid_inv_tb_top;

    localparam int N  = 8;
    localparam int IW = 3;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  ie_cap;
    logic        hi_wr;
    logic [31:0] hi_wdata;
    logic [31:0] hi_img;
    logic [IW-1:0] ent_idx;
    logic [25:0] lo0_in, lo1_in;
    logic        wr_en, rd_en, probe_en, inv_asid_en, inv_all_en;
    logic [31:0] lk_va;
    logic        lk_hit, lk_valid, lk_dirty;
    logic [31:0] lk_pa;
    logic [2:0]  lk_attr;
    logic        prb_valid, rd_valid;
    logic [31:0] prb_index, rd_hi, rd_lo0, rd_lo1;

    always #4 clk = ~clk;

    tlb_asid_inv #(.N_ENTRIES(N)) dut_i (
        .clk(clk), .rst(rst), .ie_cap(ie_cap), .hi_wr(hi_wr), .hi_wdata(hi_wdata),
        .hi_img(hi_img), .ent_idx(ent_idx), .lo0_in(lo0_in), .lo1_in(lo1_in),
        .wr_en(wr_en), .rd_en(rd_en), .probe_en(probe_en), .inv_asid_en(inv_asid_en),
        .inv_all_en(inv_all_en), .lk_va(lk_va), .lk_hit(lk_hit), .lk_pa(lk_pa),
        .lk_valid(lk_valid), .lk_dirty(lk_dirty), .lk_attr(lk_attr),
        .prb_valid(prb_valid), .prb_index(prb_index), .rd_valid(rd_valid),
        .rd_hi(rd_hi), .rd_lo0(rd_lo0), .rd_lo1(rd_lo1)
    );

    // Behavioural table model
    bit        m_hid  [N];
    bit [18:0] m_vpn  [N];
    bit [7:0]  m_asid [N];
    bit        m_g    [N];
    bit [24:0] m_ev   [N];
    bit [24:0] m_od   [N];
    bit [31:0] m_hi;
    bit        m_pv, m_rv;
    bit [31:0] m_pi, m_rh, m_rl0, m_rl1;

    int    checks = 0;
    int    fails  = 0;
    int    cycles = 0;
    bit    done   = 0;
    string phase  = "R1";

    always @(posedge clk) begin : model
        bit        ieon;
        bit [31:0] h;
        int        c;
        int        f;
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                m_hid[i] = 1; m_vpn[i] = 0; m_asid[i] = 0; m_g[i] = 0; m_ev[i] = 0; m_od[i] = 0;
            end
            m_hi = 0; m_pv = 0; m_pi = 0; m_rv = 0; m_rh = 0; m_rl0 = 0; m_rl1 = 0;
        end else begin
            ieon = (ie_cap >= 2);
            h    = m_hi;
            if (wr_en)                    c = 1;
            else if (inv_all_en && ieon)  c = 2;
            else if (inv_asid_en && ieon) c = 3;
            else if (rd_en)               c = 4;
            else if (probe_en)            c = 5;
            else                          c = 0;
            m_pv = (c == 5);
            m_rv = (c == 4);
            if (c == 5) begin
                f = -1;
                for (int i = 0; i < N; i++)
                    if (f < 0 && !m_hid[i] && (m_g[i] || m_asid[i] == h[7:0]) && m_vpn[i] == h[31:13])
                        f = i;
                m_pi = (f < 0) ? 32'h8000_0000 : 32'(f);
            end
            if (c == 4) begin
                if (m_hid[ent_idx]) begin
                    m_rh = 32'h400; m_rl0 = 0; m_rl1 = 0;
                end else begin
                    m_rh  = {m_vpn[ent_idx], 13'b0} | 32'(m_asid[ent_idx]);
                    m_rl0 = {6'b0, m_ev[ent_idx], m_g[ent_idx]};
                    m_rl1 = {6'b0, m_od[ent_idx], m_g[ent_idx]};
                end
            end
            if (c == 1) begin
                if (h[10]) m_hid[ent_idx] = 1;
                else begin
                    m_hid[ent_idx]  = 0;
                    m_vpn[ent_idx]  = h[31:13];
                    m_asid[ent_idx] = h[7:0];
                    m_g[ent_idx]    = lo0_in[0] & lo1_in[0];
                    m_ev[ent_idx]   = lo0_in[25:1];
                    m_od[ent_idx]   = lo1_in[25:1];
                end
            end
            if (c == 2) for (int i = 0; i < N; i++) m_hid[i] = 1;
            if (c == 3) for (int i = 0; i < N; i++) if (!m_g[i] && m_asid[i] == h[7:0]) m_hid[i] = 1;
            if (hi_wr) m_hi = hi_wdata & (32'hFFFF_E0FF | (ieon ? 32'h400 : 32'h0));
        end
    end

    task automatic finish_run();
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            fails++;
            $display("FAIL watchdog (all requirements) actual=%0d cycles expected<=100000", cycles);
            finish_run();
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s [phase %s] %s actual=%h expected=%h t=%0t", req, phase, what, act, exp, $time);
        end
    endtask

    task automatic check_cycle();
        int        f = -1;
        bit [24:0] pg;
        bit [31:0] epa;
        string     tag;
        for (int i = 0; i < N; i++)
            if (f < 0 && !m_hid[i] && (m_g[i] || m_asid[i] == m_hi[7:0]) && m_vpn[i] == lk_va[31:13])
                f = i;
        // R2 hit decision
        chk(lk_hit === (f >= 0), "R2", "lk_hit", 32'(lk_hit), 32'(f >= 0));
        if (f >= 0) begin
            pg  = lk_va[12] ? m_od[f] : m_ev[f];
            epa = {pg[24:5], lk_va[11:0]};
            // R3 half select and physical address
            chk(lk_pa === epa, "R3", "lk_pa", lk_pa, epa);
            chk({lk_attr, lk_dirty, lk_valid} === pg[4:0], "R3", "lk_attr/dirty/valid",
                32'({lk_attr, lk_dirty, lk_valid}), 32'(pg[4:0]));
        end
        // R11 high image masking
        chk(hi_img === m_hi, "R11", "hi_img", hi_img, m_hi);
        chk(prb_valid === m_pv, "R12", "prb_valid", 32'(prb_valid), 32'(m_pv));
        if (m_pv) chk(prb_index === m_pi, "R12", "prb_index", prb_index, m_pi);
        chk(rd_valid === m_rv, "R7", "rd_valid", 32'(rd_valid), 32'(m_rv));
        if (m_rv) begin
            tag = m_rh[10] ? "R6" : "R7";
            chk(rd_hi === m_rh, tag, "rd_hi", rd_hi, m_rh);
            chk(rd_lo0 === m_rl0, tag, "rd_lo0", rd_lo0, m_rl0);
            chk(rd_lo1 === m_rl1, tag, "rd_lo1", rd_lo1, m_rl1);
        end
    endtask

    task automatic idle();
        hi_wr = 0; wr_en = 0; rd_en = 0; probe_en = 0; inv_asid_en = 0; inv_all_en = 0;
    endtask

    task automatic tick();
        @(negedge clk);
        if (!rst) check_cycle();
        idle();
    endtask

    task automatic set_hi(input logic [31:0] v);
        hi_wr = 1; hi_wdata = v; tick();
    endtask

    task automatic write_ent(input int idx, input logic [31:0] hi, input logic [25:0] l0, input logic [25:0] l1);
        set_hi(hi);
        wr_en = 1; ent_idx = IW'(idx); lo0_in = l0; lo1_in = l1; tick();
    endtask

    task automatic read_ent(input int idx);
        rd_en = 1; ent_idx = IW'(idx); tick(); tick();
    endtask

    task automatic look(input logic [31:0] va);
        lk_va = va; tick();
    endtask

    task automatic probe(input logic [31:0] hi);
        set_hi(hi); probe_en = 1; tick(); tick();
    endtask

    function automatic logic [25:0] mk_lo(input int pfn, input int attr, input bit d, input bit v, input bit g);
        return {20'(pfn), 3'(attr), d, v, g};
    endfunction

    initial begin
        rst = 1; ie_cap = 2'd3; idle(); hi_wdata = 0; ent_idx = 0; lo0_in = 0; lo1_in = 0; lk_va = 0;
        repeat (3) tick();
        rst = 0;

        // R1: nothing hits and probes miss straight after reset
        phase = "R1";
        for (int v = 0; v < 4; v++) look({19'(v), 13'h0});
        probe(32'h0);
        read_ent(0);

        // R4/R7: fill the table and read it back
        phase = "R4";
        for (int i = 0; i < N; i++)
            write_ent(i, {19'(i + 1), 5'b0, 8'(i % 3 + 1)},
                      mk_lo(i * 16 + 5, i, i[0], 1, (i >= 6) || (i == 5)),
                      mk_lo(i * 16 + 9, 7 - i, !i[0], i != 2, i >= 6));
        phase = "R7";
        for (int i = 0; i < N; i++) read_ent(i);

        // R2/R3: lookups under two address spaces, both halves
        phase = "R2";
        set_hi(32'h1);
        for (int i = 0; i < N + 1; i++) begin
            look({19'(i + 1), 1'b0, 12'h3A5});
            look({19'(i + 1), 1'b1, 12'hC5A});
        end
        phase = "R3";
        set_hi(32'h2);
        for (int i = 0; i < N; i++) look({19'(i + 1), 1'b1, 12'h001});

        // R12: duplicate tag, lowest index wins; then a miss
        phase = "R12";
        write_ent(4, {19'd2, 5'b0, 8'd2}, mk_lo(77, 1, 1, 1, 0), mk_lo(78, 2, 0, 1, 0));
        probe({19'd2, 5'b0, 8'd2});
        probe({19'h7FF, 5'b0, 8'd2});
        look({19'd2, 13'h0});

        // R5/R6: hide one entry through a write with the hide bit
        phase = "R5";
        write_ent(3, 32'h0000_0400 | {19'd4, 13'h0}, mk_lo(1, 1, 1, 1, 1), mk_lo(1, 1, 1, 1, 1));
        set_hi(32'h1);
        look({19'd4, 13'h0});
        phase = "R6";
        read_ent(3);

        // R8: address-space invalidate; tag field of the high image is unrelated
        phase = "R8";
        set_hi({19'h555, 5'b0, 8'd2});
        inv_asid_en = 1; tick();
        for (int s = 1; s <= 3; s++) begin
            set_hi(32'(s));
            for (int i = 0; i < N; i++) look({19'(i + 1), 13'h0});
        end
        for (int i = 0; i < N; i++) read_ent(i);

        // R9: invalidate-all hides global entries too
        phase = "R9";
        inv_all_en = 1; tick();
        for (int i = 0; i < N; i++) look({19'(i + 1), 13'h0});
        read_ent(7);

        // R10: capability below 2 disables invalidates and the hide bit
        phase = "R10";
        ie_cap = 2'd1;
        for (int i = 0; i < N; i++)
            write_ent(i, {19'(i + 1), 5'b0, 8'd1}, mk_lo(i, 0, 0, 1, i == 0), mk_lo(i, 0, 0, 1, i == 0));
        inv_all_en = 1; tick();
        inv_asid_en = 1; tick();
        for (int i = 0; i < N; i++) look({19'(i + 1), 13'h0});
        write_ent(2, 32'h0000_0400 | {19'd3, 13'h0} | 32'h1, mk_lo(3, 3, 1, 1, 0), mk_lo(4, 4, 0, 0, 0));
        look({19'd3, 13'h0});
        ie_cap = 2'd2;

        // R11: junk bits are stripped from the high image
        phase = "R11";
        set_hi(32'hFFFF_FFFF);
        ie_cap = 2'd0;
        set_hi(32'hFFFF_FFFF);
        ie_cap = 2'd3;

        // R13: simultaneous strobes, write wins
        phase = "R13";
        set_hi({19'd6, 5'b0, 8'd1});
        wr_en = 1; rd_en = 1; probe_en = 1; inv_all_en = 1; inv_asid_en = 1;
        ent_idx = 3'd5; lo0_in = mk_lo(99, 5, 1, 1, 0); lo1_in = mk_lo(98, 6, 1, 0, 0);
        tick(); tick();
        look({19'd6, 1'b1, 12'h0});
        inv_all_en = 1; rd_en = 1; tick(); tick();

        // Random mix over a small tag and space pool
        phase = "random";
        for (int k = 0; k < 4000; k++) begin
            if ($urandom_range(0, 15) == 0) ie_cap = 2'($urandom_range(0, 3));
            lk_va    = (32'($urandom_range(1, 4)) << 13) | ($urandom & 32'h1FFF);
            hi_wr    = ($urandom_range(0, 2) == 0);
            hi_wdata = (32'($urandom_range(1, 4)) << 13) | 32'($urandom_range(1, 3)) |
                       (($urandom_range(0, 5) == 0) ? 32'h400 : 32'h0) | ($urandom & 32'h1B00);
            wr_en       = ($urandom_range(0, 3) == 0);
            rd_en       = ($urandom_range(0, 3) == 0);
            probe_en    = ($urandom_range(0, 3) == 0);
            inv_asid_en = ($urandom_range(0, 15) == 0);
            inv_all_en  = ($urandom_range(0, 40) == 0);
            ent_idx     = IW'($urandom_range(0, N - 1));
            lo0_in      = 26'($urandom);
            lo1_in      = 26'($urandom);
            if ($urandom_range(0, 3) == 0) begin lo0_in[0] = 1; lo1_in[0] = 1; end
            tick();
        end

        tick();
        finish_run();
    end

endmodule